// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable ratio built from two counts. A dual-modulus prescaler divides by M or by M+1, where M is either 64 or 128 depending on a select input. A swallow counter holds the prescaler at M+1 for the first A prescaler pulses of every division cycle. After that the prescaler divides by M. A main counter counts N prescaler pulses per cycle. The full cycle is therefore M·N+A input clocks long. The block emits one pulse on `fp_o` per cycle, and that pulse is the comparison frequency fed to a phase detector.

The prescaler is modelled as synchronous logic clocked by the input clock. The swallow count, main count and select are taken from the inputs only on the edge that starts a cycle, so a cycle that is already running is never cut short or stretched. The modulus-control level is brought out on `mc_o`.

Top module: `pulse_swallow_div`

## Requirements
- R1: With `fast_sel_i` high (M = 64), the distance between consecutive rising edges of `fp_o` is 64·N+A clock cycles.
- R2: With `fast_sel_i` low (M = 128), the distance between consecutive rising edges of `fp_o` is 128·N+A clock cycles.
- R3: `mc_o` rises together with `fp_o` at each cycle start when A is non-zero. It stays high for exactly A prescaler pulses, which is A·(M+1) clocks. It is then low for the rest of the cycle.
- R4: When A is 0, `mc_o` stays low for the whole cycle and the cycle lasts M·N clocks.
- R5: `fp_o` is high for exactly one clock cycle per division cycle.
- R6: `swallow_i`, `main_i` and `fast_sel_i` are sampled only on the edge where `fp_o` rises. A change made in the middle of a cycle leaves that cycle's length unchanged and applies from the next cycle on.
- R7: While `rst_ni` is low, `fp_o` and `mc_o` are low. The first rising clock edge after release loads the inputs and starts a cycle. `fp_o` then first rises M·N+A edges later.
- R8: The range limits divide correctly: N = 5 with A = 4, and N = 2047 with A = 127. Values with N below 5, or with A not smaller than N, are outside the supported range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous reset |
| swallow_i | input | A_W (7) | Swallow count A, binary |
| main_i | input | N_W (11) | Main count N, binary |
| fast_sel_i | input | 1 | High selects the 64/65 prescaler, low selects 128/129 |
| fp_o | output | 1 | One-clock pulse at the end of each division cycle |
| mc_o | output | 1 | Modulus control, high while the prescaler divides by M+1 |

## Verification
The bound checker watches several properties on every clock. It confirms that `fp_o` is one clock wide and that `mc_o` rises only at a cycle boundary. It confirms that `mc_o` stays low whenever the latched A is zero and that the latched settings hold still between boundaries. It also counts the clocks between pulses and compares each interval with M·N+A built from the settings latched at the cycle start. Some behaviours can only be shown by the directed scenarios. These cover the exact count of clocks spent at M+1, the delay from reset release to the first pulse, the two ends of the legal range, and the case where settings are rewritten in the middle of a cycle.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned DEF_A_W      = 7;
  localparam int unsigned DEF_N_W      = 11;
  localparam int unsigned DEF_DIV_FAST = 64;
  localparam int unsigned DEF_DIV_SLOW = 128;
  localparam int unsigned MIN_MAIN     = 5;
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned DIV_FAST = 64,
  parameter int unsigned DIV_SLOW = 128,
  parameter int unsigned PW       = $clog2(DIV_SLOW + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic fast_i,
  input  logic mc_i,
  output logic tick_o
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last_v;

  // terminal count is modulus-1, one extra clock while mc is high
  always_comb begin
    last_v = (fast_i ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1)) + PW'(mc_i);
    tick_o = (cnt_q == last_v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + PW'(1);
  end
endmodule

// File: rtl/psd_swallow.sv
module psd_swallow #(
  parameter int unsigned A_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic [A_W-1:0] a_next_i,
  input  logic [A_W-1:0] a_lat_i,
  input  logic           tick_i,
  output logic           mc_o
);
  logic [A_W-1:0] cnt_q;
  logic           mc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mc_q  <= 1'b0;
    end else if (restart_i) begin
      cnt_q <= '0;
      mc_q  <= (a_next_i != '0);
    end else if (tick_i && mc_q) begin
      cnt_q <= cnt_q + A_W'(1);
      if (cnt_q == a_lat_i - A_W'(1)) mc_q <= 1'b0;
    end
  end

  assign mc_o = mc_q;
endmodule

// File: rtl/psd_main.sv
module psd_main #(
  parameter int unsigned N_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           tick_i,
  input  logic [N_W-1:0] n_lat_i,
  output logic           last_o
);
  logic [N_W-1:0] cnt_q;

  assign last_o = tick_i && (cnt_q == n_lat_i - N_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + N_W'(1);
  end
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
  parameter int unsigned A_W      = psd_pkg::DEF_A_W,
  parameter int unsigned N_W      = psd_pkg::DEF_N_W,
  parameter int unsigned DIV_FAST = psd_pkg::DEF_DIV_FAST,
  parameter int unsigned DIV_SLOW = psd_pkg::DEF_DIV_SLOW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] swallow_i,
  input  logic [N_W-1:0] main_i,
  input  logic           fast_sel_i,
  output logic           fp_o,
  output logic           mc_o
);
  localparam int unsigned PW = $clog2(DIV_SLOW + 1);

  logic           start_q;
  logic [A_W-1:0] a_lat;
  logic [N_W-1:0] n_lat;
  logic           sel_lat;
  logic           fp_q;
  logic           pre_tick;
  logic           main_last;
  logic           cyc_end;
  logic           reload;

  assign cyc_end = main_last && !start_q;
  assign reload  = start_q || cyc_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b1;
      a_lat   <= '0;
      n_lat   <= '0;
      sel_lat <= 1'b0;
      fp_q    <= 1'b0;
    end else begin
      start_q <= 1'b0;
      fp_q    <= cyc_end;
      // settings move only at a cycle boundary
      if (reload) begin
        a_lat   <= swallow_i;
        n_lat   <= main_i;
        sel_lat <= fast_sel_i;
      end
    end
  end

  psd_prescaler #(
    .DIV_FAST(DIV_FAST),
    .DIV_SLOW(DIV_SLOW),
    .PW      (PW)
  ) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(reload),
    .fast_i   (sel_lat),
    .mc_i     (mc_o),
    .tick_o   (pre_tick)
  );

  psd_swallow #(.A_W(A_W)) u_swl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(reload),
    .a_next_i (swallow_i),
    .a_lat_i  (a_lat),
    .tick_i   (pre_tick),
    .mc_o     (mc_o)
  );

  psd_main #(.N_W(N_W)) u_main (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(reload),
    .tick_i   (pre_tick),
    .n_lat_i  (n_lat),
    .last_o   (main_last)
  );

  assign fp_o = fp_q;
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int unsigned A_W      = 7,
  parameter int unsigned N_W      = 11,
  parameter int unsigned DIV_FAST = 64,
  parameter int unsigned DIV_SLOW = 128
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           fp_o,
  input logic           mc_o,
  input logic [A_W-1:0] a_lat,
  input logic [N_W-1:0] n_lat,
  input logic           sel_lat
);
  localparam int unsigned CW = A_W + N_W + $clog2(DIV_SLOW + 1) + 1;

  logic          seen_fp;
  logic          exp_vld;
  logic          legal_q;
  logic [CW-1:0] gap_cnt;
  logic [CW-1:0] exp_q;
  logic [CW-1:0] exp_now;
  logic          legal_now;

  always_comb begin
    exp_now   = (sel_lat ? CW'(DIV_FAST) : CW'(DIV_SLOW)) * CW'(n_lat) + CW'(a_lat);
    legal_now = (n_lat >= N_W'(psd_pkg::MIN_MAIN)) && (N_W'(a_lat) < n_lat);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_fp <= 1'b0;
      exp_vld <= 1'b0;
      legal_q <= 1'b0;
      gap_cnt <= '0;
      exp_q   <= '0;
    end else if (fp_o) begin
      seen_fp <= 1'b1;
      exp_vld <= 1'b1;
      legal_q <= legal_now;
      gap_cnt <= CW'(1);
      exp_q   <= exp_now;
    end else begin
      gap_cnt <= gap_cnt + CW'(1);
    end
  end

  // R5
  fp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_o |=> !fp_o);

  // R3
  mc_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_fp && $rose(mc_o)) |-> fp_o);

  // R4
  zero_swallow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_lat == '0) |-> !mc_o);

  // R6
  hold_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_fp && !fp_o) |-> ($stable(a_lat) && $stable(n_lat) && $stable(sel_lat)));

  // R1 R2
  interval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_vld && legal_q && fp_o) |-> (gap_cnt == exp_q));
endmodule

bind pulse_swallow_div psd_checker #(
  .A_W     (A_W),
  .N_W     (N_W),
  .DIV_FAST(DIV_FAST),
  .DIV_SLOW(DIV_SLOW)
) u_psd_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fp_o   (fp_o),
  .mc_o   (mc_o),
  .a_lat  (a_lat),
  .n_lat  (n_lat),
  .sel_lat(sel_lat)
);

// File: tb/pulse_swallow_div_test.sv
`timescale 1ns/1ps
module pulse_swallow_div_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  swallow_i = 7'd2;
  logic [10:0] main_i = 11'd5;
  logic        fast_sel_i = 1'b1;
  logic        fp_o;
  logic        mc_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  pulse_swallow_div uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .swallow_i (swallow_i),
    .main_i    (main_i),
    .fast_sel_i(fast_sel_i),
    .fp_o      (fp_o),
    .mc_o      (mc_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int modulus(input logic sel);
    return sel ? 64 : 128;
  endfunction

  // entered at a negedge where fp_o is high; leaves at the next such negedge
  task automatic run_cycle(output int len, output int mc_hi, output int fp_hi, output int mc_first);
    len = 0; mc_hi = 0; fp_hi = 0; mc_first = int'(mc_o);
    forever begin
      if (mc_o) mc_hi++;
      if (fp_o) fp_hi++;
      len++;
      @(negedge clk_i);
      if (fp_o) break;
    end
  endtask

  task automatic t_cfg(input int a, input int n, input logic sel, input string req);
    int len, mh, fh, mf, m;
    m = modulus(sel);
    swallow_i = 7'(a); main_i = 11'(n); fast_sel_i = sel;
    run_cycle(len, mh, fh, mf);
    run_cycle(len, mh, fh, mf);
    check({req, " interval"}, len, m * n + a);
    check({"R3 ", req, " mc high clocks"}, mh, a * (m + 1));
    check({"R3 ", req, " mc at start"}, mf, (a != 0) ? 1 : 0);
    check({"R5 ", req, " fp width"}, fh, 1);
  endtask

  task automatic t_reset();
    int cnt;
    repeat (3) begin
      @(negedge clk_i);
      check("R7 fp in reset", int'(fp_o), 0);
      check("R7 mc in reset", int'(mc_o), 0);
    end
    rst_ni = 1'b1;
    cnt = 0;
    forever begin
      @(negedge clk_i);
      cnt++;
      if (cnt == 1) check("R7 mc after load", int'(mc_o), 1);
      if (fp_o) break;
    end
    check("R7 first fp delay", cnt, 64 * 5 + 2 + 1);
  endtask

  task automatic t_midchange();
    int len, mh, fh, mf;
    t_cfg(1, 20, 1'b1, "R1 pre-change");
    len = 0;
    forever begin
      len++;
      @(negedge clk_i);
      if (len == 300) begin
        swallow_i = 7'd6; main_i = 11'd9; fast_sel_i = 1'b0;
      end
      if (fp_o) break;
    end
    check("R6 running cycle unchanged", len, 64 * 20 + 1);
    run_cycle(len, mh, fh, mf);
    check("R6 next cycle uses new values", len, 128 * 9 + 6);
    check("R6 mc high clocks new", mh, 6 * 129);
  endtask

  initial begin
    t_reset();
    t_cfg(3, 10, 1'b1, "R1");
    t_cfg(5, 12, 1'b0, "R2");
    t_cfg(0, 7, 1'b1, "R4");
    t_cfg(4, 5, 1'b0, "R8 min");
    t_midchange();
    t_cfg(127, 2047, 1'b1, "R8 max");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule